// File: doc/BRIEF.md
# EEPROM write-protection unit

This block guards writes to a 2 Mbit serial EEPROM. It holds the device's protection state: a lock-enable bit that can freeze the status register, and a two-bit region code that selects how much of the upper address space is read-only. Decoded requests arrive from the command front end. A status-register update carries a new byte. A data write carries an 18-bit byte address and a flag that marks the 256-byte identification page instead of the main array. The block answers every request with a one-cycle grant or reject pulse.

The external write-protect pin is active low and is taken at the same clock edge as the request. The status register can be frozen only when the stored lock-enable bit is set and the pin is low at that edge. Driving the pin high releases the freeze. The current status byte is always visible for status reads. The block does not do serial shifting, opcode decoding, write-enable latching, array storage or program timing.

Top module: `eewp_guard`

## Requirements
- R1: After reset the status byte reads 8'h00 and all four grant and reject outputs are low.
- R2: The status byte holds the lock-enable bit at bit 7 and the region code at bits 3:2 (bit 3 is the high bit of the code). All other bits always read 0, even when a write sets them.
- R3: While the lock-enable bit is 0, a status write is accepted at any pin level. The new value appears on the status byte one cycle later, with a one-cycle status grant pulse.
- R4: While the lock-enable bit is 1 and the pin is high at the request edge, a status write is accepted in the same way as in R3.
- R5: While the lock-enable bit is 1 and the pin is low at the request edge, a status write is discarded. The status byte stays unchanged and a one-cycle status reject pulse follows. This holds whether the pin went low before or after the bit was set.
- R6: The pin level used for the lock decision is the level present at the same clock edge as the request, so raising the pin in the request cycle unlocks that request.
- R7: With region code 00, every array write and every identification-page write is granted.
- R8: With region code 01, array writes to addresses 30000h and above are rejected, and lower addresses are granted.
- R9: With region code 10, array writes to addresses 20000h and above are rejected, and lower addresses are granted.
- R10: With region code 11, every array write and every identification-page write is rejected.
- R11: The identification page is protected only by region code 11. Under codes 01 and 10 its writes are granted.
- R12: Each data write request gives exactly one of the data grant or data reject outputs, high for one cycle, in the cycle after the request. Both are low after a cycle with no data write, including a cycle with only a status write. The decision uses the region code held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wp_n_i | input | 1 | External write-protect pin, active low |
| sr_wr_req_i | input | 1 | Status-register write request, one cycle |
| sr_wr_data_i | input | 8 | New status byte for the request |
| dat_wr_req_i | input | 1 | Array or identification-page write request, one cycle |
| dat_wr_addr_i | input | 18 | Byte address of the data write |
| dat_wr_idpage_i | input | 1 | 1 when the data write targets the identification page |
| sr_grant_o | output | 1 | Status write accepted, one-cycle pulse |
| sr_reject_o | output | 1 | Status write discarded, one-cycle pulse |
| dat_grant_o | output | 1 | Data write allowed, one-cycle pulse |
| dat_reject_o | output | 1 | Data write blocked, one-cycle pulse |
| status_o | output | 8 | Current status byte |

## Verification
The region decision is driven from a table. Each region code is tried with addresses one byte below and exactly at its window base, with the top address, and with the identification page. This separates an off-by-one base or a swapped code from a correct window, and an identification page that is wrongly tied to the partial codes from one tied only to the full code. The status lock is tried with the pin low and high while the lock bit is clear, and with the bit set first and the pin lowered later, or the pin lowered first and the bit set later. A pin raised in the request cycle itself separates same-edge sampling from a delayed copy. Status writes with all bits set show that the unused bit positions stay at zero.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

  localparam int STAT_W   = 8;
  localparam int LOCK_BIT = 7;
  localparam int RGN_HI   = 3;
  localparam int RGN_LO   = 2;

  typedef enum logic [1:0] {
    RGN_NONE    = 2'b00,
    RGN_QUARTER = 2'b01,
    RGN_HALF    = 2'b10,
    RGN_ALL     = 2'b11
  } region_e;

  typedef struct packed {
    logic    lock_en;
    region_e region;
  } prot_t;

  function automatic prot_t unpack_status(input logic [STAT_W-1:0] b);
    prot_t p;
    p.lock_en = b[LOCK_BIT];
    p.region  = region_e'(b[RGN_HI:RGN_LO]);
    return p;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input prot_t p);
    logic [STAT_W-1:0] b;
    b                = '0;
    b[LOCK_BIT]      = p.lock_en;
    b[RGN_HI:RGN_LO] = p.region;
    return b;
  endfunction

endpackage

// File: rtl/eewp_status_reg.sv
module eewp_status_reg
  import eewp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              wr_req_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output prot_t             prot_o,
  output logic              accept_o,
  output logic              discard_o
);

  prot_t prot_q;
  prot_t prot_d;
  logic  frozen;

  // The pin is taken live at the request edge.
  always_comb begin
    frozen    = prot_q.lock_en & ~wp_n_i;
    accept_o  = wr_req_i & ~frozen;
    discard_o = wr_req_i & frozen;
    prot_d    = prot_q;
    if (accept_o) begin
      prot_d = unpack_status(wr_data_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
    end else if (accept_o) begin
      prot_q <= prot_d;
    end
  end

  assign prot_o = prot_q;

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && prot_q.lock_en && !wp_n_i) |=> (prot_q == $past(prot_q))); // R5

  AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && (!prot_q.lock_en || wp_n_i)) |=> (prot_q.lock_en == $past(wr_data_i[LOCK_BIT]))); // R3

endmodule

// File: rtl/eewp_region.sv
module eewp_region
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  region_e           region_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              idpage_i,
  output logic              hit_o
);

  localparam int                N_CODES = 4;
  localparam logic [ADDR_W-1:0] HALF_BASE    = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] QUARTER_BASE = {2'b11, {(ADDR_W-2){1'b0}}};

  logic [N_CODES-1:0] arr_hit;

  // One window compare per region code.
  for (genvar k = 0; k < N_CODES; k++) begin : g_code
    if (k == int'(RGN_NONE)) begin : g_none
      assign arr_hit[k] = 1'b0;
    end else if (k == int'(RGN_QUARTER)) begin : g_qtr
      assign arr_hit[k] = (addr_i >= QUARTER_BASE);
    end else if (k == int'(RGN_HALF)) begin : g_half
      assign arr_hit[k] = (addr_i >= HALF_BASE);
    end else begin : g_all
      assign arr_hit[k] = 1'b1;
    end
  end

  always_comb begin
    if (idpage_i) begin
      hit_o = (region_i == RGN_ALL);
    end else begin
      hit_o = arr_hit[region_i];
    end
  end

endmodule

// File: rtl/eewp_guard.sv
module eewp_guard
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              dat_wr_req_i,
  input  logic [ADDR_W-1:0] dat_wr_addr_i,
  input  logic              dat_wr_idpage_i,
  output logic              sr_grant_o,
  output logic              sr_reject_o,
  output logic              dat_grant_o,
  output logic              dat_reject_o,
  output logic [7:0]        status_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  prot_t prot;
  logic  sr_accept;
  logic  sr_discard;
  logic  rgn_hit;

  eewp_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wp_n_i    (wp_n_i),
    .wr_req_i  (sr_wr_req_i),
    .wr_data_i (sr_wr_data_i),
    .prot_o    (prot),
    .accept_o  (sr_accept),
    .discard_o (sr_discard)
  );

  eewp_region #(.ADDR_W(ADDR_W)) u_rgn (
    .region_i (prot.region),
    .addr_i   (dat_wr_addr_i),
    .idpage_i (dat_wr_idpage_i),
    .hit_o    (rgn_hit)
  );

  // Response pulses: next state, then register.
  logic sr_grant_d, sr_reject_d, dat_grant_d, dat_reject_d;
  logic sr_grant_q, sr_reject_q, dat_grant_q, dat_reject_q;

  always_comb begin
    sr_grant_d   = sr_accept;
    sr_reject_d  = sr_discard;
    dat_grant_d  = dat_wr_req_i & ~rgn_hit;
    dat_reject_d = dat_wr_req_i & rgn_hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sr_grant_q   <= 1'b0;
      sr_reject_q  <= 1'b0;
      dat_grant_q  <= 1'b0;
      dat_reject_q <= 1'b0;
    end else begin
      sr_grant_q   <= sr_grant_d;
      sr_reject_q  <= sr_reject_d;
      dat_grant_q  <= dat_grant_d;
      dat_reject_q <= dat_reject_d;
    end
  end

  assign sr_grant_o   = sr_grant_q;
  assign sr_reject_o  = sr_reject_q;
  assign dat_grant_o  = dat_grant_q;
  assign dat_reject_o = dat_reject_q;
  assign status_o     = pack_status(prot);

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_o & 8'h73) == 8'h00); // R2

  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sr_wr_req_i && status_o[7] && !wp_n_i) |=> (sr_reject_o && !sr_grant_o && $stable(status_o))); // R5

  AST_SR_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sr_wr_req_i && (!status_o[7] || wp_n_i)) |=> (sr_grant_o && (status_o == ($past(sr_wr_data_i) & 8'h8C)))); // R3

  AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dat_wr_req_i && status_o[3:2] == 2'b11) |=> dat_reject_o); // R10

  AST_OPEN_ALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dat_wr_req_i && status_o[3:2] == 2'b00) |=> dat_grant_o); // R7

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dat_wr_req_i |=> (dat_grant_o ^ dat_reject_o)); // R12

  AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dat_wr_req_i |=> (!dat_grant_o && !dat_reject_o)); // R12

endmodule

// File: tb/eewp_guard_tb.sv
`timescale 1ns/1ps
module eewp_guard_tb;

  logic        clk;
  logic        rst_n;
  logic        wp_n;
  logic        sr_req;
  logic [7:0]  sr_data;
  logic        d_req;
  logic [17:0] d_addr;
  logic        d_idp;
  logic        sr_gnt, sr_rej, d_gnt, d_rej;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;

  eewp_guard u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .wp_n_i          (wp_n),
    .sr_wr_req_i     (sr_req),
    .sr_wr_data_i    (sr_data),
    .dat_wr_req_i    (d_req),
    .dat_wr_addr_i   (d_addr),
    .dat_wr_idpage_i (d_idp),
    .sr_grant_o      (sr_gnt),
    .sr_reject_o     (sr_rej),
    .dat_grant_o     (d_gnt),
    .dat_reject_o    (d_rej),
    .status_o        (status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Status write: present at a falling edge, results settled one cycle later.
  task automatic sr_write(input logic [7:0] data, input logic pin);
    @(negedge clk);
    wp_n = pin; sr_req = 1'b1; sr_data = data;
    @(negedge clk);
    sr_req = 1'b0;
  endtask

  task automatic dat_write(input logic [17:0] addr, input logic idp);
    @(negedge clk);
    d_req = 1'b1; d_addr = addr; d_idp = idp;
    @(negedge clk);
    d_req = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  rgn;
    logic        idp;
    logic [17:0] addr;
    logic        ok;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 1'b0, 18'h00000, 1'b1, 8'd7},  // R7
    '{2'b00, 1'b0, 18'h3FFFF, 1'b1, 8'd7},  // R7
    '{2'b00, 1'b1, 18'h00000, 1'b1, 8'd7},  // R7
    '{2'b01, 1'b0, 18'h2FFFF, 1'b1, 8'd8},  // R8
    '{2'b01, 1'b0, 18'h30000, 1'b0, 8'd8},  // R8
    '{2'b01, 1'b0, 18'h3FFFF, 1'b0, 8'd8},  // R8
    '{2'b01, 1'b1, 18'h000FF, 1'b1, 8'd11}, // R11
    '{2'b10, 1'b0, 18'h1FFFF, 1'b1, 8'd9},  // R9
    '{2'b10, 1'b0, 18'h20000, 1'b0, 8'd9},  // R9
    '{2'b10, 1'b0, 18'h2ABCD, 1'b0, 8'd9},  // R9
    '{2'b10, 1'b1, 18'h00003, 1'b1, 8'd11}, // R11
    '{2'b11, 1'b0, 18'h00000, 1'b0, 8'd10}, // R10
    '{2'b11, 1'b0, 18'h1FFFF, 1'b0, 8'd10}, // R10
    '{2'b11, 1'b1, 18'h00000, 1'b0, 8'd10}  // R10
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wp_n = 1'b1; sr_req = 1'b0; sr_data = '0;
    d_req = 1'b0; d_addr = '0; d_idp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(status == 8'h00, "R1 status", status, 8'h00);
    chk({sr_gnt, sr_rej, d_gnt, d_rej} == 4'b0, "R1 pulses", {sr_gnt, sr_rej, d_gnt, d_rej}, 0);

    // R12 idle cycles give no answer
    repeat (2) @(negedge clk);
    chk({d_gnt, d_rej} == 2'b00, "R12 idle", {d_gnt, d_rej}, 0);

    // Region table walk
    for (int i = 0; i < NV; i++) begin
      sr_write({4'b0000, VEC[i].rgn, 2'b00}, 1'b1);
      dat_write(VEC[i].addr, VEC[i].idp);
      chk({d_gnt, d_rej} == {VEC[i].ok, ~VEC[i].ok}, $sformatf("R%0d vec %0d", VEC[i].req, i),
          {d_gnt, d_rej}, {VEC[i].ok, ~VEC[i].ok});
      @(negedge clk);
      chk({d_gnt, d_rej} == 2'b00, "R12 pulse width", {d_gnt, d_rej}, 0);
    end

    // R2 unused bits stay zero
    sr_write(8'hFF, 1'b1);
    chk(status == 8'h8C, "R2 layout", status, 8'h8C);

    // R4 lock bit set, pin high: accepted
    sr_write(8'h04, 1'b1);
    chk(sr_gnt && !sr_rej && status == 8'h04, "R4 accept", {sr_gnt, sr_rej, status}, {2'b10, 8'h04});

    // R3 lock bit clear, pin low: accepted (sets bit while pin low)
    sr_write(8'h80, 1'b0);
    chk(sr_gnt && status == 8'h80, "R3 accept pin low", {sr_gnt, status}, {1'b1, 8'h80});

    // R5 now frozen
    sr_write(8'h0C, 1'b0);
    chk(sr_rej && !sr_gnt && status == 8'h80, "R5 frozen", {sr_gnt, sr_rej, status}, {2'b01, 8'h80});
    chk({d_gnt, d_rej} == 2'b00, "R12 status-only cycle", {d_gnt, d_rej}, 0);

    // R6 pin raised in the request cycle unlocks
    sr_write(8'h88, 1'b1);
    chk(sr_gnt && status == 8'h88, "R6 same edge", {sr_gnt, status}, {1'b1, 8'h88});

    // R5 pin lowered after the bit was set
    @(negedge clk); wp_n = 1'b0;
    sr_write(8'h00, 1'b0);
    chk(sr_rej && status == 8'h88, "R5 pin lowered later", {sr_rej, status}, {1'b1, 8'h88});

    // R9 region still frozen at code 10
    dat_write(18'h20000, 1'b0);
    chk(d_rej && !d_gnt, "R9 frozen region", {d_gnt, d_rej}, 2'b01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule